// File: doc/BRIEF.md
# Programmable Edge-Triggered Delay Timer

This block is a synchronous one-shot. A rising edge on one trigger input or a falling edge on the other starts a single output pulse. The pulse lasts a power-of-two number of timebase ticks, and a 4-bit select code chooses that number. The block runs on one system clock. A tick-enable input serves as its timebase, so no separate oscillator is needed. Both trigger inputs pass through a two-flop synchronizer and then an edge detector.

A mode input sets how the block treats a trigger that arrives while a pulse is active. In one setting the trigger restarts the full delay, and in the other it is ignored. A run-mode input sets whether the timebase is free-running or passed through only while a pulse is active. The gated timebase is brought out on a port. An asynchronous active-high clear ends any pulse at once. A synchronous active-low reset brings the block to its idle state at power-up.

Top module: `delay_timer`

## Requirements
- R1: A low-to-high change on `trig_a` starts a pulse. `pulse` goes high on the third rising clock edge after the input changes: two synchronizer stages, then the edge detector. A high-to-low change on `trig_a` has no effect.
- R2: A high-to-low change on `trig_b` starts a pulse with the same latency. A low-to-high change on `trig_b` has no effect.
- R3: With `trig_a` and `trig_b` driven from one signal, each rising edge and each falling edge of that signal produces exactly one pulse.
- R4: The pulse lasts 2^E counted ticks. For `sel` bit 3 = 0, E = `sel[2:0]` + 1, giving 2 to 256. For `sel` bit 3 = 1, E = `sel[2:0]` + 17, giving 2^17 to 2^24. With `tick` held high, this is 2^E clock cycles.
- R5: `pulse_n` is always the complement of `pulse`. The idle state is `pulse`=0, `pulse_n`=1.
- R6: With `retrig`=1, a trigger edge during a pulse clears the count in the cycle it is detected. The pulse then ends 2^E ticks after that edge.
- R7: With `retrig`=0, trigger edges during a pulse are ignored. The pulse keeps its original length, and no later pulse results.
- R8: Suppose a trigger is detected in the same cycle as the final tick. With `retrig`=1 the pulse continues with a fresh count. With `retrig`=0 the pulse ends and the trigger is dropped.
- R9: `sel` is captured when the pulse starts. Changes to `sel` during the pulse do not alter its length.
- R10: Raising `mclr` forces `pulse` low and `pulse_n` high at once, with no clock edge needed. It also clears the count.
- R11: While `rst_n` is low at a clock edge, the block goes idle with the count cleared.
- R12: `base_tick` follows `tick` when `run_free`=1. When `run_free`=0, `base_tick` follows `tick` only while a pulse is active and is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclr | input | 1 | Asynchronous active-high clear that ends a pulse |
| trig_a | input | 1 | Trigger input; a rising edge starts a pulse |
| trig_b | input | 1 | Trigger input; a falling edge starts a pulse |
| retrig | input | 1 | 1 = a trigger restarts an active pulse, 0 = ignored |
| run_free | input | 1 | 1 = timebase runs always, 0 = only during a pulse |
| tick | input | 1 | Timebase tick enable |
| sel | input | 4 | Pulse-length select code |
| pulse | output | 1 | Active-high pulse output |
| pulse_n | output | 1 | Active-low pulse output |
| base_tick | output | 1 | Timebase tick after run-mode gating |

## Verification
Each trigger input is driven alone with both edge directions, which separates the active edge from the inactive one. The two inputs are also driven as one tied signal, so that both edge directions must each give one pulse. A second edge is applied during a pulse at two points, mid-count and on the final tick, in both retrigger settings. The resulting widths tell a restart apart from an ignored trigger and from a spurious extra pulse. Pulse widths taken from both halves of the select table expose a wrong exponent mapping. A select change during a pulse, a clear during a pulse and the gated timebase output in both run modes cover the remaining behaviour.

// File: rtl/dt_pkg.sv
// Shared types for the delay timer.
package dt_pkg;
    // Detected trigger events, one bit per trigger input.
    typedef struct packed {
        logic rise_a;
        logic fall_b;
    } dt_trig_t;
endpackage

// File: rtl/dt_edge_sync.sv
// Synchronizes one asynchronous input and flags a single-cycle edge of the
// chosen polarity. Assumes STAGES >= 2. During reset all stages load the
// input, so no edge is reported for a level that is already present.
module dt_edge_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] sh;
    logic              prev;

    // Shift the input through the synchronizer and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= {STAGES{din}};
            prev <= din;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    // Pick the edge polarity.
    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev & ~sh[STAGES-1];
        end else begin : g_rise
            assign edge_o = ~prev & sh[STAGES-1];
        end
    endgenerate

    // R1: a detected edge lasts exactly one cycle
    a_r1_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/dt_pulse_core.sv
// Pulse state and power-of-two delay counter. Captures the exponent at each
// accepted trigger and counts gated ticks until 2^E are seen. Assumes
// CNT_W >= 2^(SEL_W-1) so that both halves of the select table fit.
module dt_pulse_core #(
    parameter int SEL_W = 4,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclr,
    input  logic             trig,
    input  logic             retrig,
    input  logic             run_free,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             active,
    output logic             base_tick
);
    localparam int LOW_W  = SEL_W - 1;
    localparam int HI_OFS = CNT_W - (1 << LOW_W);
    localparam int EXP_W  = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic [EXP_W-1:0] exp_q;
    logic [EXP_W-1:0] exp_new;
    logic             term;

    // Map the select code to an exponent (low half 1.., high half HI_OFS+1..).
    always_comb begin
        if (sel[SEL_W-1])
            exp_new = EXP_W'(sel[LOW_W-1:0]) + EXP_W'(HI_OFS + 1);
        else
            exp_new = EXP_W'(sel[LOW_W-1:0]) + EXP_W'(1);
    end

    // Terminal mask: the low exp_q bits set.
    always_comb begin
        for (int i = 0; i < CNT_W; i++)
            mask[i] = (i < int'(exp_q));
    end

    assign base_tick = tick & (run_free | active);
    assign term      = active & base_tick & (cnt == mask);

    // Start, restart, count and finish the pulse; mclr overrides all.
    always_ff @(posedge clk or posedge mclr) begin
        if (mclr) begin
            active <= 1'b0;
            cnt    <= '0;
            exp_q  <= '0;
        end else if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            exp_q  <= '0;
        end else if (trig && (!active || retrig)) begin
            active <= 1'b1;
            cnt    <= '0;
            exp_q  <= exp_new;
        end else if (term) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active && base_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: the count stages are clear whenever no pulse is active
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        !active |-> cnt == '0);
    // R4: the count never passes the programmed terminal value
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        active |-> cnt <= mask);
    // R6: an accepted retrigger restarts the count from zero
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (active && trig && retrig) |=> (active && cnt == '0));
    // R7: without retrigger, only the terminal tick ends a pulse
    a_r7_keep_running: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (active && !retrig && !term) |=> active);
endmodule

// File: rtl/delay_timer.sv
// Top of the programmable delay timer: two edge synchronizers feed the
// pulse core. Assumes trig_a idles low and trig_b idles high, but any
// level present during reset is taken without producing an edge.
module delay_timer #(
    parameter int SEL_W     = 4,
    parameter int CNT_W     = 24,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclr,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic             retrig,
    input  logic             run_free,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse,
    output logic             pulse_n,
    output logic             base_tick
);
    import dt_pkg::*;

    dt_trig_t ev;
    logic     active;

    dt_edge_sync #(.STAGES(SYNC_STGS), .FALLING(1'b0)) i_sync_a (
        .clk(clk), .rst_n(rst_n), .din(trig_a), .edge_o(ev.rise_a));

    dt_edge_sync #(.STAGES(SYNC_STGS), .FALLING(1'b1)) i_sync_b (
        .clk(clk), .rst_n(rst_n), .din(trig_b), .edge_o(ev.fall_b));

    dt_pulse_core #(.SEL_W(SEL_W), .CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .trig(ev.rise_a | ev.fall_b),
        .retrig(retrig), .run_free(run_free), .tick(tick), .sel(sel),
        .active(active), .base_tick(base_tick));

    assign pulse   = active;
    assign pulse_n = ~active;
endmodule

// File: tb/test_delay_timer.sv
`timescale 1ns/1ps
module test_delay_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclr = 1'b0;
    logic       trig_a = 1'b0;
    logic       trig_b = 1'b1;
    logic       retrig = 1'b0;
    logic       run_free = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] sel = 4'd0;
    logic       pulse, pulse_n, base_tick;

    typedef struct {
        int    width;
        string req;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    run = 0;
    bit    bad_n = 1'b0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    delay_timer i_delay_timer (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .trig_a(trig_a), .trig_b(trig_b),
        .retrig(retrig), .run_free(run_free), .tick(tick), .sel(sel),
        .pulse(pulse), .pulse_n(pulse_n), .base_tick(base_tick));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic expect_pulse(input int w, input string req);
        item_t it;
        it.width = w;
        it.req   = req;
        exp_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: measure each high pulse and compare it with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_n !== ~pulse) bad_n = 1'b1;
            if (pulse === 1'b1) begin
                run++;
            end else if (run != 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected pulse", run, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(run == it.width, it.req, run, it.width);
                end
                check(!bad_n, "R5 complement", int'(bad_n), 0);
                run = 0;
            end
        end
    end

    initial begin
        step(3);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R11 reset idle", int'(pulse), 0);
        rst_n = 1'b1;
        step(2);
        // R12: gated timebase idle vs free-running
        check(base_tick == 1'b0, "R12 gated idle", int'(base_tick), 0);
        run_free = 1'b1;
        #0.5;
        check(base_tick == 1'b1, "R12 free idle", int'(base_tick), 1);
        run_free = 1'b0;
        step(1);

        // R1/R4: rising edge on A, two lengths
        sel = 4'd0; expect_pulse(2, "R1 R4 sel0");
        trig_a = 1'b1; step(1); trig_a = 1'b0; step(20);
        sel = 4'd3; expect_pulse(16, "R1 R4 sel3 and R12 gated in pulse");
        trig_a = 1'b1; step(6);
        check(base_tick == 1'b1, "R12 gated active", int'(base_tick), 1);
        trig_a = 1'b0; step(30);

        // R2: falling edge on B; its rising edge does nothing
        sel = 4'd1; expect_pulse(4, "R2 fall on B");
        trig_b = 1'b0; step(20);

        // R3: both inputs tied, both edge directions
        sel = 4'd2; expect_pulse(8, "R3 tied rising");
        trig_a = 1'b1; trig_b = 1'b1; step(20);
        expect_pulse(8, "R3 tied falling");
        trig_a = 1'b0; trig_b = 1'b0; step(20);
        trig_b = 1'b1; step(10);

        // R6: retrigger mid-count restarts the delay
        retrig = 1'b1; sel = 4'd3; expect_pulse(26, "R6 retrigger");
        trig_a = 1'b1; step(3); trig_a = 1'b0; step(7); trig_a = 1'b1;
        step(40); trig_a = 1'b0; step(5);

        // R7: same stimulus, trigger ignored
        retrig = 1'b0; expect_pulse(16, "R7 no retrigger");
        trig_a = 1'b1; step(3); trig_a = 1'b0; step(7); trig_a = 1'b1;
        step(40); trig_a = 1'b0; step(5);

        // R8: trigger on the terminal tick
        retrig = 1'b1; sel = 4'd0; expect_pulse(4, "R8 terminal retrigger");
        trig_a = 1'b1; step(1); trig_a = 1'b0; step(1); trig_a = 1'b1; step(1);
        trig_a = 1'b0; step(20);
        retrig = 1'b0; expect_pulse(2, "R8 terminal no retrigger");
        trig_a = 1'b1; step(1); trig_a = 1'b0; step(1); trig_a = 1'b1; step(1);
        trig_a = 1'b0; step(20);

        // R9: select change during pulse has no effect
        sel = 4'd2; expect_pulse(8, "R9 select held");
        trig_a = 1'b1; step(4); sel = 4'd0; trig_a = 1'b0; step(20);

        // R10: asynchronous clear mid-pulse
        sel = 4'd3; expect_pulse(4, "R10 clear width");
        trig_a = 1'b1; step(3); step(4);
        mclr = 1'b1;
        #0.5;
        check(pulse == 1'b0 && pulse_n == 1'b1, "R10 immediate clear", int'(pulse), 0);
        step(1); mclr = 1'b0; trig_a = 1'b0; step(20);

        // R4: upper half of the select table (2^17)
        sel = 4'd8; expect_pulse(131072, "R4 sel8");
        trig_a = 1'b1; step(1); trig_a = 1'b0; step(131072 + 20);

        check(exp_q.size() == 0, "R7 all pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R4 watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule